// File: doc/BRIEF.md
# Color-Based Cache Set Remapper

This block sits between the physical address of a last-level cache access and the cache's set index decoder. It cuts each address into four fields: a line offset, a set number inside a color, a region identifier and a tag. It looks the region identifier up in a mapping table that software can rewrite. The table returns a cache color, and the block joins that color with the set-inside-color bits to form the set index the cache arrays use. The address the processor issues is never changed. Only the index the cache sees moves.

Software programs the table through a write port that takes one entry per cycle. A second write port sets or clears a per-color enable bit, so the active cache can shrink to any subset of colors. A lookup that lands on a disabled color still yields a well-defined index, and an error flag marks it. Every result is registered, so the lookup takes one clock cycle.

Top module: `color_remap_top`

## Requirements
- R1: After a synchronous active-high reset, region r maps to color r and every color is enabled. The set index output therefore equals address bits [17:6], and `out_valid` and `out_color_off` are 0 while reset is held.
- R2: The offset output is address bits [5:0] and the tag output is address bits [57:18] of the access.
- R3: The set index output is {color from the table entry selected by address bits [17:12], address bits [11:6]}. The color forms bits [11:6] of the index.
- R4: Outputs are registered. `out_valid` in cycle n+1 equals `acc_valid` in cycle n, and the fields belong to the access of cycle n.
- R5: A table write is used by every access in a later cycle. An access in the same cycle as the write sees the entry's earlier content.
- R6: A color-enable write takes effect for accesses in later cycles. An access whose color is disabled raises `out_color_off` and still presents the index formed per R3.
- R7: A table write changes only the addressed entry.
- R8: `out_color_off` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access address is present |
| acc_addr | input | 58 | Physical address of the access |
| map_we | input | 1 | Write one mapping-table entry |
| map_region | input | 6 | Region identifier of the entry written |
| map_color | input | 6 | Color stored into that entry |
| pwr_we | input | 1 | Write one color-enable bit |
| pwr_color | input | 6 | Color whose enable bit is written |
| pwr_on | input | 1 | New enable value (1 = powered) |
| out_valid | output | 1 | Registered result is valid |
| out_set | output | 12 | Remapped set index {color, set inside color} |
| out_tag | output | 40 | Tag field of the access |
| out_offset | output | 6 | Line offset of the access |
| out_color_off | output | 1 | Access mapped to a disabled color |

## Verification
The bench builds the block with its default widths: 6-bit offset, set-inside-color, region and color fields and a 40-bit tag. At these widths all 64 table entries and all 64 enable bits can be swept and rewritten within a short run. A behavioural model holds integer arrays for the table and the enables and is compared with the outputs every cycle. This reaches the identity state after reset, writes issued in the same cycle as an access to the entry being written, and lookups of disabled colors.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DEF_OFF_W    = 6;
  localparam int DEF_SETIN_W  = 6;
  localparam int DEF_REGION_W = 6;
  localparam int DEF_COLOR_W  = 6;
  localparam int DEF_TAG_W    = 40;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
  parameter int IDX_W   = remap_pkg::DEF_REGION_W,
  parameter int COLOR_W = remap_pkg::DEF_COLOR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [COLOR_W-1:0] wcolor,
  input  logic [IDX_W-1:0]   ridx,
  output logic [COLOR_W-1:0] rcolor
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COLOR_W-1:0] mem [DEPTH];

  // Read sees contents before any write in the same cycle.
  assign rcolor = mem[ridx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= COLOR_W'(i);
    end else if (we) begin
      mem[widx] <= wcolor;
    end
  end

  a_r5_entry_written: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(widx)] == $past(wcolor));
endmodule

// File: rtl/color_mask.sv
module color_mask #(
  parameter int COLOR_W = remap_pkg::DEF_COLOR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [COLOR_W-1:0] wcolor,
  input  logic               won,
  input  logic [COLOR_W-1:0] qcolor,
  output logic               qon
);
  localparam int NCOL = 1 << COLOR_W;

  logic [NCOL-1:0] on_bits;

  assign qon = on_bits[qcolor];

  always_ff @(posedge clk) begin
    if (rst)     on_bits <= '1;
    else if (we) on_bits[wcolor] <= won;
  end

  a_r6_enable_written: assert property (@(posedge clk) disable iff (rst)
    we |=> on_bits[$past(wcolor)] == $past(won));
endmodule

// File: rtl/color_remap_top.sv
module color_remap_top #(
  parameter int OFF_W    = remap_pkg::DEF_OFF_W,
  parameter int SETIN_W  = remap_pkg::DEF_SETIN_W,
  parameter int REGION_W = remap_pkg::DEF_REGION_W,
  parameter int COLOR_W  = remap_pkg::DEF_COLOR_W,
  parameter int TAG_W    = remap_pkg::DEF_TAG_W,
  localparam int ADDR_W  = OFF_W + SETIN_W + REGION_W + TAG_W,
  localparam int SET_W   = COLOR_W + SETIN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                map_we,
  input  logic [REGION_W-1:0] map_region,
  input  logic [COLOR_W-1:0]  map_color,
  input  logic                pwr_we,
  input  logic [COLOR_W-1:0]  pwr_color,
  input  logic                pwr_on,
  output logic                out_valid,
  output logic [SET_W-1:0]    out_set,
  output logic [TAG_W-1:0]    out_tag,
  output logic [OFF_W-1:0]    out_offset,
  output logic                out_color_off
);
  localparam int SETIN_LO  = OFF_W;
  localparam int REGION_LO = OFF_W + SETIN_W;
  localparam int TAG_LO    = REGION_LO + REGION_W;

  logic [OFF_W-1:0]    f_off;
  logic [SETIN_W-1:0]  f_setin;
  logic [REGION_W-1:0] f_region;
  logic [TAG_W-1:0]    f_tag;
  logic [COLOR_W-1:0]  look_color;
  logic                look_on;

  assign f_off    = acc_addr[OFF_W-1:0];
  assign f_setin  = acc_addr[SETIN_LO +: SETIN_W];
  assign f_region = acc_addr[REGION_LO +: REGION_W];
  assign f_tag    = acc_addr[TAG_LO +: TAG_W];

  remap_table #(.IDX_W(REGION_W), .COLOR_W(COLOR_W)) u_table (
    .clk(clk), .rst(rst), .we(map_we), .widx(map_region), .wcolor(map_color),
    .ridx(f_region), .rcolor(look_color)
  );

  color_mask #(.COLOR_W(COLOR_W)) u_mask (
    .clk(clk), .rst(rst), .we(pwr_we), .wcolor(pwr_color), .won(pwr_on),
    .qcolor(look_color), .qon(look_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_set       <= '0;
      out_tag       <= '0;
      out_offset    <= '0;
      out_color_off <= 1'b0;
    end else begin
      out_valid     <= acc_valid;
      out_color_off <= acc_valid & ~look_on;
      if (acc_valid) begin
        out_set    <= {look_color, f_setin};
        out_tag    <= f_tag;
        out_offset <= f_off;
      end
    end
  end

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
  a_r2_tag_carried: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_tag == $past(f_tag) && out_offset == $past(f_off));
  a_r3_low_index_bits: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_set[SETIN_W-1:0] == $past(f_setin));
  a_r8_no_error_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_color_off);
endmodule

// File: tb/test_color_remap_top.sv
module test_color_remap_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [57:0] acc_addr = '0;
  logic        map_we = 1'b0;
  logic [5:0]  map_region = '0;
  logic [5:0]  map_color = '0;
  logic        pwr_we = 1'b0;
  logic [5:0]  pwr_color = '0;
  logic        pwr_on = 1'b0;
  logic        out_valid;
  logic [11:0] out_set;
  logic [39:0] out_tag;
  logic [5:0]  out_offset;
  logic        out_color_off;

  int checks = 0;
  int failures = 0;
  int mdl_map [64];
  bit mdl_on [64];

  always #2 clk = ~clk;

  color_remap_top i_color_remap_top (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .map_we(map_we), .map_region(map_region), .map_color(map_color),
    .pwr_we(pwr_we), .pwr_color(pwr_color), .pwr_on(pwr_on),
    .out_valid(out_valid), .out_set(out_set), .out_tag(out_tag),
    .out_offset(out_offset), .out_color_off(out_color_off)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model, then compare at the next negedge.
  task automatic step(input bit v, input logic [57:0] a,
                      input bit mw, input int mreg, input int mcol,
                      input bit ew, input int ecol, input bit eon,
                      input string req);
    bit          e_err;
    logic [11:0] e_set;
    int          c;
    acc_valid = v; acc_addr = a;
    map_we = mw; map_region = 6'(mreg); map_color = 6'(mcol);
    pwr_we = ew; pwr_color = 6'(ecol); pwr_on = eon;
    c = mdl_map[a[17:12]];
    e_set = {6'(c), a[11:6]};
    e_err = v && !mdl_on[c];
    if (mw) mdl_map[mreg] = mcol;
    if (ew) mdl_on[ecol] = eon;
    @(negedge clk);
    chk(out_valid == v, "R4", "valid", out_valid, v);
    chk(out_color_off == e_err, v ? "R6" : "R8", "color_off", out_color_off, e_err);
    if (v) begin
      chk(out_tag == a[57:18], "R2", "tag", out_tag, a[57:18]);
      chk(out_offset == a[5:0], "R2", "offset", out_offset, a[5:0]);
      chk(out_set == e_set, req, "set", out_set, e_set);
    end
  endtask

  function automatic logic [57:0] mk(input int region, input int setin);
    return {{$urandom, $urandom} >> 24, 6'(region), 6'(setin), 6'($urandom)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mdl_map[i] = i; mdl_on[i] = 1'b1; end
    rst = 1'b1;
    acc_valid = 1'b1;
    acc_addr = mk(3, 3);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_color_off == 1'b0, "R1", "color_off in reset", out_color_off, 0);
    rst = 1'b0;
    // R1: identity map after reset
    for (int r = 0; r < 64; r++) begin
      logic [57:0] a;
      a = mk(r, 63 - r);
      step(1, a, 0, 0, 0, 0, 0, 0, "R1");
      chk(out_set == a[17:6], "R1", "identity set", out_set, a[17:6]);
    end
    // R5: write in same cycle as access to that region sees old entry
    step(1, mk(5, 9), 1, 5, 40, 0, 0, 0, "R5");
    chk(out_set[11:6] == 6'd5, "R5", "same-cycle color", out_set[11:6], 5);
    step(1, mk(5, 9), 0, 0, 0, 0, 0, 0, "R5");
    chk(out_set[11:6] == 6'd40, "R5", "later color", out_set[11:6], 40);
    // R7: neighbours untouched
    step(1, mk(4, 1), 0, 0, 0, 0, 0, 0, "R7");
    chk(out_set[11:6] == 6'd4, "R7", "neighbour 4", out_set[11:6], 4);
    step(1, mk(6, 2), 0, 0, 0, 0, 0, 0, "R7");
    chk(out_set[11:6] == 6'd6, "R7", "neighbour 6", out_set[11:6], 6);
    step(1, mk(40, 2), 0, 0, 0, 0, 0, 0, "R7");
    // R6: disable color 40; same-cycle access not flagged, later one flagged
    step(1, mk(5, 7), 0, 0, 0, 1, 40, 0, "R6");
    chk(out_color_off == 1'b0, "R6", "same-cycle disable", out_color_off, 0);
    step(1, mk(5, 7), 0, 0, 0, 0, 0, 0, "R6");
    chk(out_color_off == 1'b1, "R6", "disabled flag", out_color_off, 1);
    chk(out_set == {6'd40, 6'd7}, "R6", "index on disabled", out_set, {6'd40, 6'd7});
    step(0, mk(5, 7), 0, 0, 0, 1, 40, 1, "R8");
    chk(out_color_off == 1'b0, "R8", "idle no flag", out_color_off, 0);
    step(1, mk(5, 7), 0, 0, 0, 0, 0, 0, "R6");
    // R4: bubbles
    for (int k = 0; k < 20; k++)
      step(k[0], mk(k, k), 0, 0, 0, 0, 0, 0, "R4");
    // R3: random traffic with writes
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, mk($urandom % 64, $urandom % 64),
           ($urandom % 6) == 0, $urandom % 64, $urandom % 64,
           ($urandom % 8) == 0, $urandom % 64, ($urandom % 3) != 0, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule